// File: doc/BRIEF.md
# Compute Token Receive Decoder

This block is the receive front end of a processing element. It accepts 16-bit flits from the interconnect under a valid/ready handshake, with a `more` wire that marks every flit of a packet except the last. The first flit (the header) alone tells the block how many flits the packet has and how its fields are laid out. The block gathers one or two flits into a token and splits out the instruction offset, activation ID, operand port, destination, subtype fields and data word.

Each finished token appears as a one-cycle strobe with a kind code and the extracted fields. Structure-memory packets are not decoded further. They are tagged with their own kind and handed on with their raw header and data word.

Malformed framing raises a one-cycle protocol-error pulse, and decoding then restarts cleanly. A header in the reserved subtype is consumed and dropped, and it sets a sticky error flag.

Top module: `tok_rx_decoder`

## Requirements
- R1: While reset is asserted, `tok_valid_o`, `proto_err_o` and `rsvd_err_o` are low. From the first clock after reset, `flit_ready_o` is high and stays high. A flit is accepted on every clock edge at which `flit_valid_i` is high.
- R2: A header with bit15=0 and bit14=0 is a dyadic token of two flits and gives kind 0. Its fields are: port = bit13, destination = [12:11], offset = [10:3], activation = [2:0]. Data is the second flit.
- R3: A header with bits[15:13]=010 is a monadic token of two flits and gives kind 1. Its fields are: destination = [12:11], offset = [10:3], activation = [2:0]. Data is the second flit.
- R4: A header with bits[15:13]=011 and subtype bits[10:9]=10 is a one-flit inline token and gives kind 2. Its fields are: destination = [12:11], offset = {0, bits[8:2]}. Data is zero.
- R5: A header with bits[15:13]=011 and subtype 00 is a frame-control token of two flits and gives kind 3. Its fields are: select = bit8 (0 allocate, 1 free), activation = [7:5], destination = [12:11]. Data is the second flit, which is the return route.
- R6: A header with bits[15:13]=011 and subtype 01 is a local-write token of two flits and gives kind 4. Its fields are: select = bit8 (0 instruction memory, 1 frame slot), slot = [7:3], activation = [2:0], destination = [12:11]. Data is the second flit, which is the value to write.
- R7: A header with bit15=1 is a structure-memory packet of two flits and gives kind 5. Its destination is [14:13]. It is passed on with its data word.
- R8: `tok_valid_o` is high for exactly the cycle after the edge that accepts a token's final flit. Idle cycles may appear between the flits of a packet. `tok_hdr_o` always carries the raw header.
- R9: `tok_spare_nz_o` is high when the spare bits are nonzero: [4:2] of a frame-control header, or [1:0] of an inline header. Spare bits change no other field.
- R10: A header with bits[15:13]=011 and subtype 11 is consumed as one flit and produces no strobe. It sets `rsvd_err_o` from the next cycle until reset.
- R11: A flit whose `more` value disagrees with the header-derived length raises a one-cycle `proto_err_o` on the next cycle. The token is dropped. The next accepted flit is decoded as a header.
- R12: Fields that a kind does not define read zero on the strobe: port, offset, activation, select and slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flit_i | input | 16 | Incoming flit |
| flit_valid_i | input | 1 | Flit present |
| flit_more_i | input | 1 | More flits follow in this packet |
| flit_ready_o | output | 1 | Block accepts a flit |
| tok_valid_o | output | 1 | Decoded token strobe |
| tok_kind_o | output | 3 | Kind code (0..5) |
| tok_hdr_o | output | 16 | Raw header flit |
| tok_dst_o | output | 2 | Destination ID |
| tok_port_o | output | 1 | Operand port |
| tok_ofs_o | output | 8 | Instruction offset |
| tok_act_o | output | 3 | Activation ID |
| tok_sel_o | output | 1 | Frame op / write region select |
| tok_slot_o | output | 5 | Local-write slot index |
| tok_data_o | output | 16 | Data word |
| tok_spare_nz_o | output | 1 | Spare bits nonzero |
| proto_err_o | output | 1 | Framing error pulse |
| rsvd_err_o | output | 1 | Sticky reserved-subtype flag |

## Verification
Every result is registered exactly once. The token strobe, its fields, the protocol-error pulse and the sticky flag are all due one cycle after the edge that accepts the deciding flit. The bench drives one flit per falling edge and predicts from its own packet model what must appear after the next rising edge. It samples at the following falling edge, so each comparison lands on the single cycle in which the result is due. Idle gaps inside packets and back-to-back one-flit tokens check that a strobe does not start early or last too long.

// File: rtl/tok_rx_pkg.sv
package tok_rx_pkg;
  localparam int FLIT_W = 16;
  localparam int OFS_W  = 8;
  localparam int ACT_W  = 3;
  localparam int SLOT_W = 5;
  localparam int DST_W  = 2;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_DYAD = 3'd0,
    K_MONA = 3'd1,
    K_INLN = 3'd2,
    K_FCTL = 3'd3,
    K_LWR  = 3'd4,
    K_MEM  = 3'd5,
    K_RSVD = 3'd6
  } tok_kind_e;

  typedef struct packed {
    logic [DST_W-1:0]  dst;
    logic              port;
    logic [OFS_W-1:0]  ofs;
    logic [ACT_W-1:0]  act;
    logic              sel;
    logic [SLOT_W-1:0] slot;
    logic              spare_nz;
  } tok_fields_t;
endpackage

// File: rtl/tok_rx_classify.sv
module tok_rx_classify
  import tok_rx_pkg::*;
(
  input  logic [FLIT_W-1:0] hdr_i,
  output tok_kind_e         kind_o,
  output logic              two_flit_o
);
  always_comb begin
    if (hdr_i[15])       kind_o = K_MEM;
    else if (!hdr_i[14]) kind_o = K_DYAD;
    else if (!hdr_i[13]) kind_o = K_MONA;
    else begin
      unique case (hdr_i[10:9])
        2'b00:   kind_o = K_FCTL;
        2'b01:   kind_o = K_LWR;
        2'b10:   kind_o = K_INLN;
        default: kind_o = K_RSVD;
      endcase
    end
  end

  assign two_flit_o = (kind_o != K_INLN) && (kind_o != K_RSVD);
endmodule

// File: rtl/tok_rx_fields.sv
module tok_rx_fields
  import tok_rx_pkg::*;
(
  input  logic [FLIT_W-1:0] hdr_i,
  input  tok_kind_e         kind_i,
  output tok_fields_t       fld_o
);
  always_comb begin
    fld_o     = '0;
    fld_o.dst = (kind_i == K_MEM) ? hdr_i[14:13] : hdr_i[12:11];
    unique case (kind_i)
      K_DYAD: begin
        fld_o.port = hdr_i[13];
        fld_o.ofs  = hdr_i[10:3];
        fld_o.act  = hdr_i[2:0];
      end
      K_MONA: begin
        fld_o.ofs = hdr_i[10:3];
        fld_o.act = hdr_i[2:0];
      end
      K_INLN: begin
        fld_o.ofs      = {1'b0, hdr_i[8:2]};
        fld_o.spare_nz = |hdr_i[1:0];
      end
      K_FCTL: begin
        fld_o.sel      = hdr_i[8];
        fld_o.act      = hdr_i[7:5];
        fld_o.spare_nz = |hdr_i[4:2];
      end
      K_LWR: begin
        fld_o.sel  = hdr_i[8];
        fld_o.slot = hdr_i[7:3];
        fld_o.act  = hdr_i[2:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tok_rx_decoder.sv
module tok_rx_decoder
  import tok_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLIT_W-1:0] flit_i,
  input  logic              flit_valid_i,
  input  logic              flit_more_i,
  output logic              flit_ready_o,
  output logic              tok_valid_o,
  output logic [KIND_W-1:0] tok_kind_o,
  output logic [FLIT_W-1:0] tok_hdr_o,
  output logic [DST_W-1:0]  tok_dst_o,
  output logic              tok_port_o,
  output logic [OFS_W-1:0]  tok_ofs_o,
  output logic [ACT_W-1:0]  tok_act_o,
  output logic              tok_sel_o,
  output logic [SLOT_W-1:0] tok_slot_o,
  output logic [FLIT_W-1:0] tok_data_o,
  output logic              tok_spare_nz_o,
  output logic              proto_err_o,
  output logic              rsvd_err_o
);
  logic              ready_q, body_q, body_d;
  logic [FLIT_W-1:0] hdr_q, hdr_src;
  logic              take, done, perr, rsv;
  tok_kind_e         kind;
  logic              two_flit;
  tok_fields_t       fld, fld_q;
  logic [FLIT_W-1:0] data_q, hdr_out_q;
  tok_kind_e         kind_q;
  logic              valid_q, perr_q, rsvd_q;

  // header comes from the wire on the first flit, from the latch on the second
  assign hdr_src = body_q ? hdr_q : flit_i;
  assign take    = flit_valid_i && ready_q;

  tok_rx_classify u_cls (.hdr_i(hdr_src), .kind_o(kind), .two_flit_o(two_flit));
  tok_rx_fields   u_fld (.hdr_i(hdr_src), .kind_i(kind), .fld_o(fld));

  always_comb begin
    done   = 1'b0;
    perr   = 1'b0;
    rsv    = 1'b0;
    body_d = body_q;
    if (take) begin
      if (body_q) begin
        body_d = 1'b0;
        if (flit_more_i) perr = 1'b1;
        else             done = 1'b1;
      end else if (kind == K_RSVD) begin
        rsv  = 1'b1;
        perr = flit_more_i;
      end else if (two_flit) begin
        if (flit_more_i) body_d = 1'b1;
        else             perr   = 1'b1;
      end else begin
        if (flit_more_i) perr = 1'b1;
        else             done = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q   <= 1'b0;
      body_q    <= 1'b0;
      hdr_q     <= '0;
      valid_q   <= 1'b0;
      perr_q    <= 1'b0;
      rsvd_q    <= 1'b0;
      kind_q    <= K_DYAD;
      fld_q     <= '0;
      data_q    <= '0;
      hdr_out_q <= '0;
    end else begin
      ready_q <= 1'b1;
      body_q  <= body_d;
      valid_q <= done;
      perr_q  <= perr;
      rsvd_q  <= rsvd_q | rsv;
      if (take && !body_q) hdr_q <= flit_i;
      if (done) begin
        kind_q    <= kind;
        fld_q     <= fld;
        hdr_out_q <= hdr_src;
        data_q    <= body_q ? flit_i : '0;
      end
    end
  end

  assign flit_ready_o   = ready_q;
  assign tok_valid_o    = valid_q;
  assign tok_kind_o     = kind_q;
  assign tok_hdr_o      = hdr_out_q;
  assign tok_dst_o      = fld_q.dst;
  assign tok_port_o     = fld_q.port;
  assign tok_ofs_o      = fld_q.ofs;
  assign tok_act_o      = fld_q.act;
  assign tok_sel_o      = fld_q.sel;
  assign tok_slot_o     = fld_q.slot;
  assign tok_spare_nz_o = fld_q.spare_nz;
  assign tok_data_o     = data_q;
  assign proto_err_o    = perr_q;
  assign rsvd_err_o     = rsvd_q;
endmodule

// File: rtl/tok_rx_decoder_chk.sv
module tok_rx_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        flit_valid_i,
  input logic        flit_ready_o,
  input logic        tok_valid_o,
  input logic [2:0]  tok_kind_o,
  input logic        tok_port_o,
  input logic [4:0]  tok_slot_o,
  input logic [2:0]  tok_act_o,
  input logic [15:0] tok_data_o,
  input logic        proto_err_o,
  input logic        rsvd_err_o
);
  assert_strobe_after_flit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_o |-> $past(flit_valid_i));

  assert_rsvd_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_err_o |=> rsvd_err_o);

  assert_err_excludes_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> !tok_valid_o);

  assert_inline_no_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && tok_kind_o == 3'd2) |-> tok_data_o == 16'h0);

  assert_mem_unused_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_o && tok_kind_o == 3'd5) |-> (tok_act_o == 3'd0 && tok_slot_o == 5'd0 && !tok_port_o));

  assert_kind_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_o |-> tok_kind_o <= 3'd5);

  assert_ready_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_ready_o |=> flit_ready_o);
endmodule

bind tok_rx_decoder tok_rx_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flit_valid_i(flit_valid_i), .flit_ready_o(flit_ready_o),
  .tok_valid_o(tok_valid_o), .tok_kind_o(tok_kind_o), .tok_port_o(tok_port_o),
  .tok_slot_o(tok_slot_o), .tok_act_o(tok_act_o), .tok_data_o(tok_data_o),
  .proto_err_o(proto_err_o), .rsvd_err_o(rsvd_err_o)
);

// File: tb/tok_rx_decoder_test.sv
module tok_rx_decoder_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] flit;
  logic flit_valid, flit_more;
  logic flit_ready, tok_valid, tok_port, tok_sel, tok_spare_nz, proto_err, rsvd_err;
  logic [2:0]  tok_kind, tok_act;
  logic [15:0] tok_hdr, tok_data;
  logic [1:0]  tok_dst;
  logic [7:0]  tok_ofs;
  logic [4:0]  tok_slot;

  int n_run = 0;
  int n_fail = 0;

  bit          m_body = 0;
  bit          m_rsv = 0;
  logic [15:0] m_hdr = '0;

  always #5 clk = ~clk;

  tok_rx_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .flit_i(flit), .flit_valid_i(flit_valid),
    .flit_more_i(flit_more), .flit_ready_o(flit_ready), .tok_valid_o(tok_valid),
    .tok_kind_o(tok_kind), .tok_hdr_o(tok_hdr), .tok_dst_o(tok_dst), .tok_port_o(tok_port),
    .tok_ofs_o(tok_ofs), .tok_act_o(tok_act), .tok_sel_o(tok_sel), .tok_slot_o(tok_slot),
    .tok_data_o(tok_data), .tok_spare_nz_o(tok_spare_nz), .proto_err_o(proto_err),
    .rsvd_err_o(rsvd_err)
  );

  // kind codes per R2..R7, 6 = reserved (R10)
  function automatic int ekind(logic [15:0] h);
    if (h[15]) return 5;
    if (!h[14]) return 0;
    if (!h[13]) return 1;
    case (h[10:9])
      2'b00: return 3;
      2'b01: return 4;
      2'b10: return 2;
      default: return 6;
    endcase
  endfunction

  function automatic bit etwo(logic [15:0] h);
    int k = ekind(h);
    return !(k == 2 || k == 6);
  endfunction

  function automatic string ktag(int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_tok(logic [15:0] h, logic [15:0] d);
    int k = ekind(h);
    string t = {ktag(k), "/R12"};
    logic [1:0] x_dst = (k == 5) ? h[14:13] : h[12:11];
    logic x_port = (k == 0) ? h[13] : 1'b0;
    logic [7:0] x_ofs = (k <= 1) ? h[10:3] : (k == 2) ? {1'b0, h[8:2]} : 8'h0;
    logic [2:0] x_act = (k <= 1 || k == 4) ? h[2:0] : (k == 3) ? h[7:5] : 3'h0;
    logic x_sel = (k == 3 || k == 4) ? h[8] : 1'b0;
    logic [4:0] x_slot = (k == 4) ? h[7:3] : 5'h0;
    logic x_sp = (k == 3) ? |h[4:2] : (k == 2) ? |h[1:0] : 1'b0;
    chk(tok_kind == 3'(k), t, "kind", 32'(tok_kind), 32'(k));
    chk(tok_hdr == h, "R8", "hdr", 32'(tok_hdr), 32'(h));
    chk(tok_dst == x_dst && tok_port == x_port && tok_ofs == x_ofs && tok_act == x_act &&
        tok_sel == x_sel && tok_slot == x_slot, t, "fields",
        {tok_dst, tok_port, tok_ofs, tok_act, tok_sel, tok_slot},
        {x_dst, x_port, x_ofs, x_act, x_sel, x_slot});
    chk(tok_data == d, t, "data", 32'(tok_data), 32'(d));
    chk(tok_spare_nz == x_sp, "R9", "spare", 32'(tok_spare_nz), 32'(x_sp));
  endtask

  // one cycle: drive at falling edge, predict, check at next falling edge
  task automatic cyc(bit v, logic [15:0] f, bit m);
    bit e_valid = 0, e_perr = 0;
    logic [15:0] e_hdr = '0, e_data = '0;
    flit_valid = v; flit = f; flit_more = m;
    if (v) begin
      if (m_body) begin
        m_body = 0;
        if (m) e_perr = 1;
        else begin e_valid = 1; e_hdr = m_hdr; e_data = f; end
      end else if (ekind(f) == 6) begin
        m_rsv = 1; e_perr = m;
      end else if (etwo(f)) begin
        if (m) begin m_body = 1; m_hdr = f; end
        else e_perr = 1;
      end else begin
        if (m) e_perr = 1;
        else begin e_valid = 1; e_hdr = f; end
      end
    end
    @(negedge clk);
    chk(tok_valid == e_valid, "R8", "strobe", 32'(tok_valid), 32'(e_valid));
    chk(proto_err == e_perr, "R11", "proto_err", 32'(proto_err), 32'(e_perr));
    chk(rsvd_err == m_rsv, "R10", "rsvd_err", 32'(rsvd_err), 32'(m_rsv));
    if (e_valid && tok_valid) check_tok(e_hdr, e_data);
  endtask

  task automatic pkt2(logic [15:0] h, logic [15:0] d, int gap);
    cyc(1, h, 1);
    for (int i = 0; i < gap; i++) cyc(0, 16'hdead, 1);
    cyc(1, d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; flit = '0; flit_valid = 0; flit_more = 0;
    repeat (3) @(negedge clk);
    chk(!tok_valid && !proto_err && !rsvd_err, "R1", "reset outputs",
        {tok_valid, proto_err, rsvd_err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(flit_ready == 1'b1, "R1", "ready", 32'(flit_ready), 1);

    pkt2(16'b0010_1101_0101_1011, 16'h1234, 0);  // R2 dyadic port 1
    pkt2(16'b0100_1110_0000_0111, 16'hbeef, 2);  // R3 monadic with gap
    cyc(1, 16'b0111_1101_1111_1100, 0);          // R4 inline
    cyc(1, 16'b0110_1101_0000_0011, 0);          // R4 inline back-to-back, spare set R9
    pkt2(16'b0111_0001_1001_1100, 16'h4321, 0);  // R5 free, spare set R9
    pkt2(16'b0110_0000_1010_0000, 16'h0f0f, 1);  // R5 allocate
    pkt2(16'b0110_1011_1111_1101, 16'h5a5a, 0);  // R6 frame region
    pkt2(16'b0111_0010_0101_0010, 16'ha5a5, 0);  // R6 instruction region
    pkt2(16'b1101_0101_0101_0101, 16'h7777, 0);  // R7 memory
    cyc(1, 16'b0010_0000_0000_0001, 0);          // R11 two-flit header, more low
    cyc(1, 16'b0111_1100_0000_0000, 1);          // R11 one-flit header, more high
    pkt2(16'b0001_0000_0000_0001, 16'h1111, 0);  // R11 resync: decodes cleanly
    cyc(1, 16'b0010_0000_0000_0001, 1);
    cyc(1, 16'h2222, 1);                         // R11 second flit with more high
    cyc(0, '0, 0);
    cyc(1, 16'b0110_0110_0000_0000, 0);          // R10 reserved
    cyc(0, '0, 0);
    cyc(1, 16'b0111_1100_0000_0100, 0);          // R10 sticky, inline still works

    for (int p = 0; p < 3000; p++) begin
      logic [15:0] h = 16'($urandom);
      bit bad = ($urandom % 16) == 0;
      if (etwo(h)) begin
        cyc(1, h, !bad);
        for (int i = 0; i < int'($urandom % 3); i++) cyc(0, 16'($urandom), 0);
        cyc(1, 16'($urandom), 0);
      end else cyc(1, h, bad);
      if ($urandom % 4 == 0) cyc(0, '0, 0);
    end
    cyc(0, '0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule